// File: doc/BRIEF.md
# Cascaded Moving-Average Motion Profile Generator

This block turns a single constant-velocity command into a smooth fourth-order motion profile. A rectangular velocity sequence, held at a peak value for a set number of samples and zero afterwards, passes through three moving-average stages in series. Each stage smooths one more derivative. The last stage's output is the commanded velocity. Position is the running sum of that velocity. Acceleration, jerk and jounce are successive first differences of it.

A host pulses `start_i` with the peak velocity, the rectangle length and three window lengths on the inputs, then supplies one `tick_i` per sample period. Each tick advances the profile by exactly one sample. Each moving-average stage keeps a circular delay line and a running window sum. The sum takes one add and one subtract per sample, and one division by the window length gives the stage output. When the whole profile has drained, `done_o` rises and the outputs hold.

Top module: `conv_traj_gen`

## Requirements
- R1: After reset every output is zero and `done_o` is low.
- R2: The first stage input on sample k (counted from 0 after a start) is the latched peak velocity when k is less than the latched duration, and zero otherwise.
- R3: Each stage output on sample k is the sum of that stage's inputs on samples k-m+1 through k divided by its window m, with truncation toward zero. Samples before the start count as zero.
- R4: `vel_o` is the third stage output and changes only on a cycle with `tick_i` high during a run. Without a tick, no output changes.
- R5: `pos_o` is the running sum of every velocity sample since the start, sign-extended to the position width.
- R6: `acc_o` is velocity minus the previous velocity, `jerk_o` is acceleration minus the previous acceleration, and `jounce_o` is jerk minus the previous jerk. The values before the first sample are zero.
- R7: After duration + m1 + m2 + m3 ticks, `done_o` is high and `vel_o` and `acc_o` are exactly zero. Later ticks change nothing until the next start.
- R8: A start accepted while idle or done clears all delay lines, sums and outputs, lowers `done_o`, and latches the peak, duration and windows. Input changes during a run have no effect.
- R9: A start pulse during a run is ignored and the profile continues unchanged.
- R10: A window input of 0 is used as 1, and a window input above MAX_WIN is used as MAX_WIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample-period strobe, one step per high cycle |
| start_i | input | 1 | Begin a new profile (accepted when not running) |
| vpeak_i | input | DW | Signed peak velocity of the input rectangle |
| dur_i | input | DUR_W | Rectangle length in samples |
| win1_i | input | WIN_W | Window length of stage 1 |
| win2_i | input | WIN_W | Window length of stage 2 |
| win3_i | input | WIN_W | Window length of stage 3 |
| vel_o | output | DW | Smoothed velocity |
| pos_o | output | PW | Accumulated position |
| acc_o | output | DW | First difference of velocity |
| jerk_o | output | DW | Second difference of velocity |
| jounce_o | output | DW | Third difference of velocity |
| done_o | output | 1 | Profile complete |

## Verification
The bench builds the block with its defaults: 32-bit samples, 48-bit position, a 16-bit duration and windows up to 64. The full delay-line depth and the pointer wrap at 64 are exercised. Window inputs of 0 and of 65 to 127 reach the clamp. Random positive and negative peaks show truncation toward zero in every stage. A zero duration, uneven tick spacing, and start pulses with altered inputs in mid-run cover the drain, hold and ignore cases.

// File: rtl/conv_traj_pkg.sv
package conv_traj_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ctg_stage.sv
module ctg_stage #(
  parameter int DW      = 32,
  parameter int MAX_WIN = 64,
  localparam int WIN_W  = $clog2(MAX_WIN + 1),
  localparam int PTR_W  = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1,
  localparam int SW     = DW + WIN_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 step_i,
  input  logic [WIN_W-1:0]     win_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] y_o
);
  logic signed [DW-1:0] dly_q [MAX_WIN];
  logic [PTR_W-1:0]     ptr_q;
  logic signed [SW-1:0] sum_q, sum_nxt, quo, divisor;
  logic signed [DW-1:0] oldest;
  logic                 ptr_wrap;

  assign oldest   = dly_q[ptr_q];
  assign sum_nxt  = sum_q + {{WIN_W{x_i[DW-1]}}, x_i} - {{WIN_W{oldest[DW-1]}}, oldest};
  assign divisor  = $signed({{(SW-WIN_W){1'b0}}, win_i});
  assign quo      = sum_nxt / divisor;
  assign y_o      = quo[DW-1:0];
  assign ptr_wrap = ({1'b0, ptr_q} == PTR_W'(win_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAX_WIN; i++) dly_q[i] <= '0;
      ptr_q <= '0;
      sum_q <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < MAX_WIN; i++) dly_q[i] <= '0;
      ptr_q <= '0;
      sum_q <= '0;
    end else if (step_i) begin
      dly_q[ptr_q] <= x_i;
      sum_q        <= sum_nxt;
      ptr_q        <= ptr_wrap ? '0 : ptr_q + 1'b1;
    end
  end

  AST_WIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (win_i >= 1 && win_i <= WIN_W'(MAX_WIN))); // R10
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> ({1'b0, ptr_q} < {1'b0, win_i})); // R3
  AST_QUO_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (quo == {{WIN_W{quo[DW-1]}}, quo[DW-1:0]})); // R3
endmodule

// File: rtl/ctg_deriv.sv
module ctg_deriv #(
  parameter int DW = 32,
  parameter int PW = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 step_i,
  input  logic signed [DW-1:0] v_i,
  output logic signed [DW-1:0] vel_o,
  output logic signed [PW-1:0] pos_o,
  output logic signed [DW-1:0] acc_o,
  output logic signed [DW-1:0] jerk_o,
  output logic signed [DW-1:0] jounce_o
);
  logic signed [DW-1:0] acc_nxt, jerk_nxt;

  assign acc_nxt  = v_i - vel_o;
  assign jerk_nxt = acc_nxt - acc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vel_o <= '0; pos_o <= '0; acc_o <= '0; jerk_o <= '0; jounce_o <= '0;
    end else if (clr_i) begin
      vel_o <= '0; pos_o <= '0; acc_o <= '0; jerk_o <= '0; jounce_o <= '0;
    end else if (step_i) begin
      vel_o    <= v_i;
      pos_o    <= pos_o + {{(PW-DW){v_i[DW-1]}}, v_i};
      acc_o    <= acc_nxt;
      jerk_o   <= jerk_nxt;
      jounce_o <= jerk_nxt - jerk_o;
    end
  end

  AST_ACC_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i |=> acc_o == vel_o - $past(vel_o)); // R6
  AST_JERK_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i |=> jerk_o == acc_o - $past(acc_o)); // R6
  AST_POS_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i |=> pos_o == $past(pos_o) + {{(PW-DW){vel_o[DW-1]}}, vel_o}); // R5
endmodule

// File: rtl/ctg_seq.sv
module ctg_seq
  import conv_traj_pkg::*;
#(
  parameter int DUR_W = 16,
  parameter int WS_W  = 9,
  localparam int CW   = ((DUR_W > WS_W) ? DUR_W : WS_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic [WS_W-1:0]  wsum_i,
  output logic             clr_o,
  output logic             step_o,
  output logic             feed_o,
  output logic             done_o
);
  seq_state_e    st_q;
  logic [CW-1:0] cnt_q, dur_q, total_q, cnt_inc;

  assign clr_o   = start_i && (st_q != ST_RUN);
  assign step_o  = tick_i && (st_q == ST_RUN);
  assign feed_o  = cnt_q < dur_q;
  assign done_o  = (st_q == ST_DONE);
  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      dur_q   <= '0;
      total_q <= '0;
    end else if (clr_o) begin
      st_q    <= ST_RUN;
      cnt_q   <= '0;
      dur_q   <= CW'(dur_i);
      total_q <= CW'(dur_i) + CW'(wsum_i);
    end else if (step_o) begin
      cnt_q <= cnt_inc;
      if (cnt_inc == total_q) st_q <= ST_DONE;
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) && start_i |=> $stable(total_q) && $stable(dur_q)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> cnt_q < total_q); // R7
endmodule

// File: rtl/conv_traj_gen.sv
module conv_traj_gen #(
  parameter int DW      = 32,
  parameter int PW      = 48,
  parameter int DUR_W   = 16,
  parameter int MAX_WIN = 64,
  localparam int WIN_W  = $clog2(MAX_WIN + 1),
  localparam int WS_W   = WIN_W + 2,
  localparam int NSTG   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 start_i,
  input  logic signed [DW-1:0] vpeak_i,
  input  logic [DUR_W-1:0]     dur_i,
  input  logic [WIN_W-1:0]     win1_i,
  input  logic [WIN_W-1:0]     win2_i,
  input  logic [WIN_W-1:0]     win3_i,
  output logic signed [DW-1:0] vel_o,
  output logic signed [PW-1:0] pos_o,
  output logic signed [DW-1:0] acc_o,
  output logic signed [DW-1:0] jerk_o,
  output logic signed [DW-1:0] jounce_o,
  output logic                 done_o
);
  function automatic logic [WIN_W-1:0] clamp_win(input logic [WIN_W-1:0] w);
    if (w == '0) return WIN_W'(1);
    if (w > WIN_W'(MAX_WIN)) return WIN_W'(MAX_WIN);
    return w;
  endfunction

  logic [WIN_W-1:0]     win_raw [NSTG];
  logic [WIN_W-1:0]     win_cl  [NSTG];
  logic [WIN_W-1:0]     win_q   [NSTG];
  logic [WS_W-1:0]      wsum;
  logic signed [DW-1:0] vpeak_q;
  logic signed [DW-1:0] chain [NSTG+1];
  logic                 clr, step, feed;

  assign win_raw[0] = win1_i;
  assign win_raw[1] = win2_i;
  assign win_raw[2] = win3_i;

  always_comb begin
    wsum = '0;
    for (int i = 0; i < NSTG; i++) begin
      win_cl[i] = clamp_win(win_raw[i]);
      wsum      = wsum + WS_W'(win_cl[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpeak_q <= '0;
      for (int i = 0; i < NSTG; i++) win_q[i] <= WIN_W'(1);
    end else if (clr) begin
      vpeak_q <= vpeak_i;
      for (int i = 0; i < NSTG; i++) win_q[i] <= win_cl[i];
    end
  end

  ctg_seq #(.DUR_W(DUR_W), .WS_W(WS_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .tick_i, .dur_i,
    .wsum_i (wsum),
    .clr_o  (clr),
    .step_o (step),
    .feed_o (feed),
    .done_o
  );

  assign chain[0] = feed ? vpeak_q : '0;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    ctg_stage #(.DW(DW), .MAX_WIN(MAX_WIN)) u_stage (
      .clk_i, .rst_ni,
      .clr_i  (clr),
      .step_i (step),
      .win_i  (win_q[g]),
      .x_i    (chain[g]),
      .y_o    (chain[g+1])
    );
  end

  ctg_deriv #(.DW(DW), .PW(PW)) u_deriv (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .step_i (step),
    .v_i    (chain[NSTG]),
    .vel_o, .pos_o, .acc_o, .jerk_o, .jounce_o
  );

  AST_DONE_AT_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vel_o == '0 && acc_o == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !start_i |=> $stable(vel_o) && $stable(pos_o) && $stable(jounce_o)); // R4
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (pos_o == '0 && vel_o == '0 && !done_o)); // R8
endmodule

// File: tb/conv_traj_gen_tb.sv
module conv_traj_gen_tb;
  localparam int DW = 32, PW = 48, DUR_W = 16, MAX_WIN = 64, WIN_W = 7, MAXN = 1024;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic signed [DW-1:0] vpeak = '0;
  logic [DUR_W-1:0] dur = '0;
  logic [WIN_W-1:0] w1 = 7'd1, w2 = 7'd1, w3 = 7'd1;
  logic signed [DW-1:0] vel, acc, jerk, jounce;
  logic signed [PW-1:0] pos;
  logic done;

  int checks = 0, errors = 0;
  bit finished = 0;
  longint seqv [4][MAXN];

  always #4 clk = ~clk;

  conv_traj_gen #(.DW(DW), .PW(PW), .DUR_W(DUR_W), .MAX_WIN(MAX_WIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start), .vpeak_i(vpeak),
    .dur_i(dur), .win1_i(w1), .win2_i(w2), .win3_i(w3),
    .vel_o(vel), .pos_o(pos), .acc_o(acc), .jerk_o(jerk), .jounce_o(jounce), .done_o(done));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clampw(input int w);
    if (w == 0) return 1;
    if (w > MAX_WIN) return MAX_WIN;
    return w;
  endfunction

  // R3: window sum over last m samples, truncated toward zero
  function automatic longint winavg(input int s, input int k, input int m);
    longint sum = 0;
    for (int j = 0; j < m; j++) if (k - j >= 0) sum += seqv[s][k-j];
    return sum / longint'(m);
  endfunction

  task automatic run_profile(input int vp, input int d, input int r1, input int r2,
                             input int r3, input bit disturb);
    int m [3];
    int n;
    longint e_vel = 0, e_acc = 0, e_jerk = 0, e_jnc = 0, e_pos = 0, nv, na, nj;
    m[0] = clampw(r1); m[1] = clampw(r2); m[2] = clampw(r3);
    n = d + m[0] + m[1] + m[2];
    @(negedge clk);
    vpeak = vp; dur = DUR_W'(d); w1 = WIN_W'(r1); w2 = WIN_W'(r2); w3 = WIN_W'(r3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 clear pos", pos, 0);
    chk("R8 clear vel", vel, 0);
    chk("R8 done low", longint'(done), 0);
    for (int k = 0; k < n; k++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk("R4 hold vel", vel, e_vel);
        chk("R4 hold pos", pos, e_pos);
      end
      if (disturb && k == n / 2) begin
        vpeak = -vp; dur = DUR_W'(d + 7); w1 = 7'd3; w2 = 7'd9; w3 = 7'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 start ignored vel", vel, e_vel);
      end
      seqv[0][k] = (k < d) ? longint'(vp) : 0; // R2
      seqv[1][k] = winavg(0, k, m[0]);
      seqv[2][k] = winavg(1, k, m[1]);
      seqv[3][k] = winavg(2, k, m[2]);
      nv = seqv[3][k];
      na = nv - e_vel; nj = na - e_acc;
      e_jnc = nj - e_jerk; e_jerk = nj; e_acc = na; e_vel = nv; e_pos += nv;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      chk("R3 R4 vel", vel, e_vel);
      chk("R5 pos", pos, e_pos);
      chk("R6 acc", acc, e_acc);
      chk("R6 jerk", jerk, e_jerk);
      chk("R6 jounce", jounce, e_jnc);
      chk("R7 done timing", longint'(done), (k == n - 1) ? 1 : 0);
    end
    chk("R7 vel zero", vel, 0);
    chk("R7 acc zero", acc, 0);
    tick = 1'b1;
    repeat (2) @(negedge clk);
    tick = 1'b0;
    chk("R7 hold pos", pos, e_pos);
    chk("R7 hold done", longint'(done), 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 vel", vel, 0);
    chk("R1 pos", pos, 0);
    chk("R1 jounce", jounce, 0);
    chk("R1 done", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk("R4 no run tick", vel, 0);
    run_profile(1000, 10, 4, 3, 2, 0);
    run_profile(-777, 25, 5, 7, 3, 0);          // R3 negative truncation
    run_profile(12345, 0, 6, 6, 6, 0);          // R2 zero duration
    run_profile(500, 8, 0, 100, 127, 0);        // R10 clamp
    run_profile(1 << 20, 70, 64, 64, 64, 0);    // full depth, pointer wrap
    run_profile(-4321, 30, 11, 5, 8, 1);        // R8 R9 mid-run start
    for (int t = 0; t < 6; t++) begin
      int vp = int'($urandom_range(0, 2000000)) - 1000000;
      run_profile(vp, $urandom_range(0, 300), $urandom_range(1, 64),
                  $urandom_range(1, 64), $urandom_range(1, 64), bit'(t % 2));
    end
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule